// File: doc/BRIEF.md
# Video Clamp Timing Pulse Generator

This block produces one clamp pulse per video line for the DC-restore stage of an analog video channel. It runs on a clock that is a fixed multiple of the line rate, nominally 224 clocks per line. It watches a regenerated horizontal sync input. After a chosen sync edge it counts a programmed number of clocks and then raises the clamp output for a fixed number of clocks.

Three clamp placements are available:

- **Sync-tip** times the pulse from the sync leading edge, so that the clamp falls inside the sync pulse. It is needed when active picture starts right after sync.
- **Back-porch** times the pulse from the sync trailing edge with a short delay. It lands between the end of sync and the start of picture, and it is the usual choice.
- **Tri-level** is also timed from the trailing edge, but with a much longer delay. This suits high-definition tri-level sync.

The placement comes from a 2-bit selector. The selector is captured at each sync edge, so a change applies from the next edge and never alters a pulse that has already started.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While reset is asserted, and until the first trigger after it, `clamp` is low. The captured mode resets to back-porch.
- R2: When `mode_sel` = 2'b01 (sync-tip), a sync leading edge (low to high) triggers the pulse. `clamp` rises on the (DLY_TIP+1)-th rising clock edge after the edge that first samples `hsync` high. The default DLY_TIP is 2.
- R3: When `mode_sel` = 2'b00 (back-porch), a sync trailing edge (high to low) triggers the pulse. `clamp` rises on the (DLY_BP+1)-th clock edge after the edge that first samples `hsync` low. The default DLY_BP is 4.
- R4: When `mode_sel` = 2'b10 (tri-level), the trailing edge triggers the pulse, with a delay of DLY_TRI. The default DLY_TRI is 20.
- R5: When `mode_sel` = 2'b11, the block behaves exactly as back-porch.
- R6: Each clamp pulse is high for exactly CLAMP_W clock cycles. The default CLAMP_W is 8.
- R7: The mode used for a trigger is the value of `mode_sel` on the clock edge that first samples the new `hsync` level. Changing `mode_sel` at any other time does not move, shorten or stretch a pending or running pulse.
- R8: A reference edge that arrives while a delay count is running restarts the delay from the new edge. Only one pulse results.
- R9: A reference edge that arrives while `clamp` is high is ignored. The running pulse keeps its full width, and no extra pulse follows.
- R10: A sync edge that is not the reference edge of the captured mode produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, a fixed multiple of the line rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | input | 1 | Regenerated horizontal sync (active level set by parameter, high by default) |
| mode_sel | input | 2 | Clamp placement: 00 back-porch, 01 sync-tip, 10 tri-level, 11 back-porch |
| clamp | output | 1 | Clamp / DC-restore pulse to the video path |

## Verification
A corrupted delay counter shows up as a pulse edge that is early or late against the reference model. That error is visible on the very cycle where `clamp` should change, which is at most DLY_TRI+CLAMP_W+2 clocks after the sync edge. A stuck or wrongly decoded mode shows up as a pulse anchored to the wrong edge, or as a missing pulse, within the same line. Corruption of the pulse-width count shows up as a pulse that is short or long by at least one cycle. The bench compares the output every clock, so each of these faults is caught on the first cycle it occurs.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
   typedef enum logic [1:0] {
      CLAMP_BACK = 2'b00,
      CLAMP_TIP  = 2'b01,
      CLAMP_TRI  = 2'b10,
      CLAMP_ALT  = 2'b11
   } clamp_mode_t;

   typedef enum logic [1:0] {
      TMR_IDLE = 2'b00,
      TMR_WAIT = 2'b01,
      TMR_HOLD = 2'b10
   } tmr_state_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/clamp_edge_det.sv
module clamp_edge_det #(
   parameter bit SYNC_HIGH = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hsync_in,
   input  logic [1:0] mode_in,
   output logic       lead_edge,
   output logic       trail_edge,
   output logic [1:0] mode_q
);
   logic sync_lvl;
   logic lvl_d1;
   logic lvl_d2;

   generate
      if (SYNC_HIGH) begin : g_pos
         assign sync_lvl = hsync_in;
      end else begin : g_neg
         assign sync_lvl = ~hsync_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d1 <= 1'b0;
         lvl_d2 <= 1'b0;
         mode_q <= 2'b00;
      end else begin
         lvl_d1 <= sync_lvl;
         lvl_d2 <= lvl_d1;
         mode_q <= mode_in;
      end
   end

   assign lead_edge  = lvl_d1 & ~lvl_d2;
   assign trail_edge = ~lvl_d1 & lvl_d2;
endmodule

// File: rtl/clamp_mode_dec.sv
module clamp_mode_dec
   import clamp_pkg::*;
#(
   parameter int DLY_TIP = 2,
   parameter int DLY_BP  = 4,
   parameter int DLY_TRI = 20,
   parameter int CNT_W   = 5
) (
   input  logic [1:0]       mode_q,
   input  logic             lead_edge,
   input  logic             trail_edge,
   output logic             trig,
   output logic [CNT_W-1:0] dly_val
);
   clamp_mode_t mode;

   assign mode = clamp_mode_t'(mode_q);

   always_comb begin
      case (mode)
         CLAMP_TIP: begin
            trig    = lead_edge;
            dly_val = CNT_W'(DLY_TIP);
         end
         CLAMP_TRI: begin
            trig    = trail_edge;
            dly_val = CNT_W'(DLY_TRI);
         end
         default: begin
            trig    = trail_edge;
            dly_val = CNT_W'(DLY_BP);
         end
      endcase
   end
endmodule

// File: rtl/clamp_timer.sv
module clamp_timer
   import clamp_pkg::*;
#(
   parameter int CNT_W   = 5,
   parameter int CLAMP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic [CNT_W-1:0] dly_val,
   output logic             wait_on,
   output logic             pulse_on
);
   localparam int WID_W = $clog2(CLAMP_W + 1);

   tmr_state_t       state;
   logic [CNT_W-1:0] dly_cnt;
   logic [WID_W-1:0] wid_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= TMR_IDLE;
         dly_cnt <= '0;
         wid_cnt <= '0;
      end else if (trig && state != TMR_HOLD) begin
         state   <= TMR_WAIT;
         dly_cnt <= dly_val;
      end else begin
         case (state)
            TMR_WAIT: begin
               if (dly_cnt == CNT_W'(1)) begin
                  state   <= TMR_HOLD;
                  wid_cnt <= WID_W'(CLAMP_W);
               end else begin
                  dly_cnt <= dly_cnt - 1'b1;
               end
            end
            TMR_HOLD: begin
               if (wid_cnt == WID_W'(1)) begin
                  state <= TMR_IDLE;
               end else begin
                  wid_cnt <= wid_cnt - 1'b1;
               end
            end
            default: state <= TMR_IDLE;
         endcase
      end
   end

   assign wait_on  = (state == TMR_WAIT);
   assign pulse_on = (state == TMR_HOLD);
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
   import clamp_pkg::*;
#(
   parameter bit SYNC_HIGH = 1'b1,
   parameter int DLY_TIP   = 2,
   parameter int DLY_BP    = 4,
   parameter int DLY_TRI   = 20,
   parameter int CLAMP_W   = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hsync,
   input  logic [1:0] mode_sel,
   output logic       clamp
);
   localparam int DLY_MAX = max3(DLY_TIP, DLY_BP, DLY_TRI);
   localparam int CNT_W   = $clog2(DLY_MAX + 1);

   generate
      if (DLY_TIP < 1 || DLY_BP < 1 || DLY_TRI < 1) begin : g_bad_dly
         $error("clamp_pulse_gen: every delay must be at least one clock");
      end
      if (CLAMP_W < 1) begin : g_bad_wid
         $error("clamp_pulse_gen: CLAMP_W must be at least one clock");
      end
   endgenerate

   logic             lead_edge;
   logic             trail_edge;
   logic [1:0]       mode_q;
   logic             trig;
   logic [CNT_W-1:0] dly_val;
   logic             timer_wait;

   clamp_edge_det #(
      .SYNC_HIGH (SYNC_HIGH)
   ) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .hsync_in   (hsync),
      .mode_in    (mode_sel),
      .lead_edge  (lead_edge),
      .trail_edge (trail_edge),
      .mode_q     (mode_q)
   );

   clamp_mode_dec #(
      .DLY_TIP (DLY_TIP),
      .DLY_BP  (DLY_BP),
      .DLY_TRI (DLY_TRI),
      .CNT_W   (CNT_W)
   ) u_dec (
      .mode_q     (mode_q),
      .lead_edge  (lead_edge),
      .trail_edge (trail_edge),
      .trig       (trig),
      .dly_val    (dly_val)
   );

   clamp_timer #(
      .CNT_W   (CNT_W),
      .CLAMP_W (CLAMP_W)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig     (trig),
      .dly_val  (dly_val),
      .wait_on  (timer_wait),
      .pulse_on (clamp)
   );
endmodule

// File: rtl/clamp_pulse_chk.sv
module clamp_pulse_chk #(
   parameter int CLAMP_W = 8
) (
   input logic clk,
   input logic rst_n,
   input logic clamp,
   input logic dly_act
);
   localparam int RUN_W = $clog2(CLAMP_W + 1) + 1;

   logic [RUN_W-1:0] run_len;
   logic [1:0]       since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len   <= '0;
         since_rst <= '0;
      end else begin
         run_len <= clamp ? run_len + 1'b1 : '0;
         if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
      end
   end

   AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < 2'd2) |-> !clamp);                                 // R1
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      clamp |-> (run_len < RUN_W'(CLAMP_W)));                          // R6
   AST_FULL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clamp) |-> (run_len == RUN_W'(CLAMP_W)));                  // R6
   AST_RISE_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clamp) |-> $past(dly_act));                                // R8
endmodule

bind clamp_pulse_gen clamp_pulse_chk #(
   .CLAMP_W (CLAMP_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clamp   (clamp),
   .dly_act (timer_wait)
);

// File: tb/clamp_pulse_gen_bench.sv
module clamp_pulse_gen_bench;
   localparam int D_TIP = 2;
   localparam int D_BP  = 4;
   localparam int D_TRI = 20;
   localparam int W     = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hsync = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic       clamp;

   int   n_vec = 0;
   int   n_bad = 0;
   bit   done = 0;

   // reference model state
   int   j = 0;
   logic hp1 = 1'b0, hp2 = 1'b0;
   logic [1:0] mp1 = 2'b00;
   int   pend = -1;
   int   s_start = 0;
   bit   s_ok = 0;
   logic exp_c = 1'b0;
   int   hi_cnt = 0;

   always #2 clk = ~clk;

   clamp_pulse_gen #(
      .SYNC_HIGH (1'b1),
      .DLY_TIP   (D_TIP),
      .DLY_BP    (D_BP),
      .DLY_TRI   (D_TRI),
      .CLAMP_W   (W)
   ) u_clamp_pulse_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .hsync    (hsync),
      .mode_sel (mode_sel),
      .clamp    (clamp)
   );

   function automatic int delay_of(input logic [1:0] m);
      if (m == 2'b01) return D_TIP;
      if (m == 2'b10) return D_TRI;
      return D_BP;
   endfunction

   function automatic logic is_trigger(input logic [1:0] m, input logic cur, input logic prv);
      if (m == 2'b01) return cur & ~prv;
      return ~cur & prv;
   endfunction

   // called at a negedge: drive, step one clock, update model, compare
   task automatic step(input logic h, input logic [1:0] m, input string tag);
      logic trig;
      hsync    = h;
      mode_sel = m;
      @(posedge clk);
      trig = is_trigger(mp1, hp1, hp2);
      if (trig && !exp_c) pend = j + delay_of(mp1);
      else if (pend == j) begin
         s_start = j;
         s_ok    = 1;
         pend    = -1;
      end
      exp_c = s_ok && (j >= s_start) && (j < s_start + W);
      hp2 = hp1;
      hp1 = h;
      mp1 = m;
      j++;
      @(negedge clk);
      n_vec++;
      if (clamp) hi_cnt++;
      if (clamp !== exp_c) begin
         n_bad++;
         $display("FAIL %s cycle %0d: clamp=%0b expected %0b", tag, j, clamp, exp_c);
      end
   endtask

   task automatic line(input logic [1:0] m, input int sw, input int gap, input string tag);
      for (int k = 0; k < sw; k++) step(1'b1, m, tag);
      for (int k = 0; k < gap; k++) step(1'b0, m, tag);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not end, actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      int unsigned r;
      logic [1:0] m;
      seed = $urandom(32'd20241);
      // R1: reset holds clamp low while sync toggles
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         hsync = k[1];
         mode_sel = 2'(k);
         #1;
         n_vec++;
         if (clamp !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: clamp=%0b expected 0", clamp);
         end
      end
      @(negedge clk);
      hsync = 1'b0;
      mode_sel = 2'b00;
      rst_n = 1'b1;
      // R1: mode register defaults to back-porch; quiet until first trigger
      for (int k = 0; k < 4; k++) step(1'b0, 2'b00, "R1");
      // R3 back-porch, R6 width check on that line
      hi_cnt = 0;
      line(2'b00, 10, 30, "R3");
      if (hi_cnt != W) begin
         n_bad++;
         $display("FAIL R6 width: high cycles=%0d expected %0d", hi_cnt, W);
      end
      n_vec++;
      line(2'b01, 12, 25, "R2");
      line(2'b10, 10, 40, "R4");
      line(2'b11, 10, 30, "R5");
      // R10: sync-tip ignores trailing edge; back-porch ignores leading edge
      line(2'b01, 30, 20, "R10");
      line(2'b00, 30, 20, "R10");
      // R8: retrigger inside tri-level delay
      line(2'b10, 3, 5, "R8");
      line(2'b10, 3, 40, "R8");
      // R9: edge inside running back-porch pulse
      line(2'b00, 3, 6, "R9");
      line(2'b00, 3, 30, "R9");
      // R7: mode change during delay and during pulse
      for (int k = 0; k < 8; k++) step(1'b1, 2'b00, "R7");
      step(1'b0, 2'b00, "R7");
      for (int k = 0; k < 3; k++) step(1'b0, 2'b10, "R7");
      for (int k = 0; k < 8; k++) step(1'b0, 2'b01, "R7");
      for (int k = 0; k < 20; k++) step(1'b0, 2'b11, "R7");
      // random lines with random mode flips (R7)
      for (int n = 0; n < 80; n++) begin
         int sw;
         int gap;
         int flip;
         r   = $urandom;
         m   = 2'(r);
         sw  = 1 + int'((r >> 2) % 24);
         gap = 1 + int'((r >> 8) % 40);
         flip = int'((r >> 16) % 64);
         for (int k = 0; k < sw; k++) step(1'b1, m, "R7");
         for (int k = 0; k < gap; k++) begin
            if (k == flip) m = 2'($urandom);
            step(1'b0, m, "R7");
         end
      end
      for (int k = 0; k < 40; k++) step(1'b0, 2'b00, "R6");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule